// File: doc/BRIEF.md
# Multi-Lane Flash Completion Poller

This block decides when an embedded program or erase operation has finished on one or more flash chips that share a data bus. After a start pulse it keeps reading one status address through a simple request/acknowledge read port. It compares each result against the word the caller expects to find once the operation is complete. The bus is split into chip lanes of a selectable width. Each lane is checked on its own, and a lane whose contents already match is dropped from every later comparison.

Polling ends with a pass as soon as every remaining lane matches. It ends with a fail in any of these cases:
- two successive reads agree on all remaining lanes without matching, which shows the status bits have stopped toggling (for example, when the address holds ordinary memory rather than flash);
- a remaining lane raises a timeout bit selected by a mask;
- a fixed budget of judged reads runs out.

To wait for an erase, the caller sets the expected word to all ones.

Top module: `flash_poll_top`

## Requirements
- R1: With the block idle, a start pulse latches the poll address, expected word, widths and timeout mask. From the next cycle busy and rd_req are high and rd_addr holds the latched address until the run ends. A start pulse while busy is ignored.
- R2: A read completes in a cycle where rd_req and rd_ack are both high. rd_ack while idle has no effect.
- R3: The first completed read of a run only records the value for the stall comparison. It is never judged, even if it equals the expected word.
- R4: Width selects use the encoding 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. At start, the compare mask covers the low bus-width bytes, byte 0 in bits 7:0. A judged read passes when its bytes under the mask equal the expected word's bytes. Bytes above the bus width are ignored.
- R5: A judged read that does not pass, and whose masked value equals the masked value of the previous read, ends the run with a fail.
- R6: Lanes are chip-width groups of bytes counted upward from byte 0. A judged read that neither passes nor stalls fails when any lane still under the mask has a lowest byte that shares a set bit with tmo_mask. A mask of zero disables this check, and a flagged bit in any other byte of the lane is ignored.
- R7: After a judged read that does not end the run, every lane whose bytes all equal the expected bytes leaves the compare mask for the rest of the run. A chip width wider than the bus width is reduced to the bus width.
- R8: The run fails on judged read number MAX_POLLS if that read has no other outcome.
- R9: Outcome priority is match, then stall, then timeout, then budget. The run ends in the cycle after the deciding read: done pulses for one cycle, busy and rd_req drop, and pass shows the result until the next accepted start.
- R10: Reset holds busy, rd_req, done and pass low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a polling run (accepted only when idle) |
| poll_addr | input | ADDR_W | Status address to read |
| expect_word | input | 8*BUS_BYTES | Data expected when the operation has finished |
| bus_width_sel | input | 2 | Bus width: 0=1, 1=2, 2/3=4 bytes |
| chip_width_sel | input | 2 | Chip lane width, same encoding |
| tmo_mask | input | 8 | Timeout bits tested in each lane's lowest byte |
| rd_req | output | 1 | Read request, held for the whole run |
| rd_addr | output | ADDR_W | Address of the read |
| rd_ack | input | 1 | Read completes this cycle with rd_data |
| rd_data | input | 8*BUS_BYTES | Read result |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Result of the last run |

## Verification
The bench builds the block with a 4-byte bus, a 16-bit address and MAX_POLLS set to 5. With that budget, both a budget failure and a match on the very last allowed read take only a handful of reads. The 4-byte bus allows one-, two- and four-byte lanes side by side. This brings within reach lane retirement, a stall that only a retired lane would have hidden, timeout bits in lowest and non-lowest lane bytes, and the clamp of a chip width wider than the bus.

// File: rtl/flash_poll_pkg.sv
// Shared types and helpers for the flash completion poller.
// Assumes byte-granular lanes and widths that are powers of two up to 8 bytes.
package flash_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_POLL  = 2'd2
    } poll_state_t;

    // Decode a width select into bytes, limited to the bus capacity.
    function automatic logic [3:0] sel_to_bytes(input logic [1:0] sel, input int unsigned cap);
        logic [3:0] w;
        w = 4'd1 << sel;
        if (int'(w) > int'(cap)) w = cap[3:0];
        return w;
    endfunction

    // Index of the lowest byte of the lane holding byte idx.
    function automatic int lane_base(input int idx, input logic [3:0] cw);
        return idx & ~(int'(cw) - 1);
    endfunction

endpackage

// File: rtl/flash_poll_lanes.sv
// Combinational evaluation of one judged read across all chip lanes.
// Produces match, stall and timeout flags plus the surviving compare mask.
// Assumes chip_bytes is a power of two no larger than BUS_BYTES.
module flash_poll_lanes
    import flash_poll_pkg::*;
#(
    parameter int BUS_BYTES = 4
) (
    input  logic [8*BUS_BYTES-1:0] rd_data,
    input  logic [8*BUS_BYTES-1:0] last_data,
    input  logic [8*BUS_BYTES-1:0] exp_data,
    input  logic [BUS_BYTES-1:0]   live,
    input  logic [3:0]             chip_bytes,
    input  logic [7:0]             tmo_mask,
    output logic                   is_match,
    output logic                   is_stall,
    output logic                   is_tmo,
    output logic [BUS_BYTES-1:0]   next_live
);
    localparam int DW = 8 * BUS_BYTES;

    logic [DW-1:0]        bit_live;
    logic [BUS_BYTES-1:0] byte_eq;
    logic [BUS_BYTES-1:0] lane_tmo;

    generate
        for (genvar b = 0; b < BUS_BYTES; b++) begin : g_byte
            logic tmo_b;
            logic keep_b;

            assign bit_live[8*b +: 8] = {8{live[b]}};
            assign byte_eq[b]         = (rd_data[8*b +: 8] == exp_data[8*b +: 8]);

            // Lane-level verdict for the lane that owns byte b.
            always_comb begin : lane_eval
                int   base;
                logic all_eq;
                logic any_live;
                base     = lane_base(b, chip_bytes);
                all_eq   = 1'b1;
                any_live = 1'b0;
                for (int j = 0; j < BUS_BYTES; j++) begin
                    if (lane_base(j, chip_bytes) == base) begin
                        all_eq   = all_eq & byte_eq[j];
                        any_live = any_live | live[j];
                    end
                end
                tmo_b  = any_live && (|(rd_data[8*base +: 8] & tmo_mask));
                keep_b = live[b] && !all_eq;
            end

            assign lane_tmo[b]  = tmo_b;
            assign next_live[b] = keep_b;
        end
    endgenerate

    // Whole-bus flags under the current compare mask.
    assign is_match = (((rd_data ^ exp_data) & bit_live) == '0);
    assign is_stall = (((rd_data ^ last_data) & bit_live) == '0);
    assign is_tmo   = |lane_tmo;

endmodule

// File: rtl/flash_poll_budget.sv
// Counts judged reads in a run and flags the last one allowed.
// Assumes LIMIT >= 1 and that the run ends no later than the flagged read.
module flash_poll_budget #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic at_limit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Judged-read counter, restarted with each run.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (step)   cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == LAST);

endmodule

// File: rtl/flash_poll_seq.sv
// Run sequencer: idle, priming read, judged reads, and the result registers.
// Assumes the lane flags are valid in any cycle where a judged read completes.
module flash_poll_seq
    import flash_poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_ack,
    input  logic is_match,
    input  logic is_stall,
    input  logic is_tmo,
    input  logic budget_last,
    output logic load_cfg,
    output logic prime_take,
    output logic judge_take,
    output logic busy,
    output logic done,
    output logic pass
);
    poll_state_t state_q;
    logic        finish;

    assign busy       = (state_q != ST_IDLE);
    assign load_cfg   = (state_q == ST_IDLE) && start;
    assign prime_take = (state_q == ST_PRIME) && rd_ack;
    assign judge_take = (state_q == ST_POLL) && rd_ack;
    assign finish     = judge_take && (is_match || is_stall || is_tmo || budget_last);

    // State progression and end-of-run result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            pass    <= 1'b0;
        end else begin
            done <= finish;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_PRIME;
                    pass    <= 1'b0;
                end
                ST_PRIME: if (rd_ack) state_q <= ST_POLL;
                ST_POLL: if (finish) begin
                    state_q <= ST_IDLE;
                    pass    <= is_match;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_poll_top.sv
// Flash completion poller top: holds the run configuration, the previous read
// and the live-lane mask, and ties together lane evaluation, budget and sequencer.
// Assumes BUS_BYTES is 1, 2, 4 or 8.
module flash_poll_top
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BUS_BYTES = 4,
    parameter int MAX_POLLS = 4096
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [ADDR_W-1:0]      poll_addr,
    input  logic [8*BUS_BYTES-1:0] expect_word,
    input  logic [1:0]             bus_width_sel,
    input  logic [1:0]             chip_width_sel,
    input  logic [7:0]             tmo_mask,
    output logic                   rd_req,
    output logic [ADDR_W-1:0]      rd_addr,
    input  logic                   rd_ack,
    input  logic [8*BUS_BYTES-1:0] rd_data,
    output logic                   busy,
    output logic                   done,
    output logic                   pass
);
    localparam int DW = 8 * BUS_BYTES;

    logic [ADDR_W-1:0]    addr_q;
    logic [DW-1:0]        exp_q;
    logic [DW-1:0]        last_q;
    logic [3:0]           chip_q;
    logic [7:0]           tmo_q;
    logic [BUS_BYTES-1:0] live_q;

    logic [3:0]           bus_b;
    logic [3:0]           chip_b;
    logic [BUS_BYTES-1:0] live_init;
    logic [BUS_BYTES-1:0] next_live;
    logic                 is_match, is_stall, is_tmo, budget_last;
    logic                 load_cfg, prime_take, judge_take;

    // Decode widths; a chip lane never exceeds the bus.
    always_comb begin
        bus_b  = sel_to_bytes(bus_width_sel, BUS_BYTES);
        chip_b = sel_to_bytes(chip_width_sel, BUS_BYTES);
        if (chip_b > bus_b) chip_b = bus_b;
    end

    generate
        for (genvar b = 0; b < BUS_BYTES; b++) begin : g_init
            assign live_init[b] = (b < int'(bus_b));
        end
    endgenerate

    // Run configuration, previous read and surviving lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            exp_q  <= '0;
            last_q <= '0;
            chip_q <= 4'd1;
            tmo_q  <= '0;
            live_q <= '0;
        end else if (load_cfg) begin
            addr_q <= poll_addr;
            exp_q  <= expect_word;
            chip_q <= chip_b;
            tmo_q  <= tmo_mask;
            live_q <= live_init;
        end else if (prime_take) begin
            last_q <= rd_data;
        end else if (judge_take) begin
            last_q <= rd_data;
            live_q <= next_live;
        end
    end

    flash_poll_lanes #(.BUS_BYTES(BUS_BYTES)) lanes_i (
        .rd_data    (rd_data),
        .last_data  (last_q),
        .exp_data   (exp_q),
        .live       (live_q),
        .chip_bytes (chip_q),
        .tmo_mask   (tmo_q),
        .is_match   (is_match),
        .is_stall   (is_stall),
        .is_tmo     (is_tmo),
        .next_live  (next_live)
    );

    flash_poll_budget #(.LIMIT(MAX_POLLS)) budget_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load_cfg),
        .step     (judge_take),
        .at_limit (budget_last)
    );

    flash_poll_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rd_ack      (rd_ack),
        .is_match    (is_match),
        .is_stall    (is_stall),
        .is_tmo      (is_tmo),
        .budget_last (budget_last),
        .load_cfg    (load_cfg),
        .prime_take  (prime_take),
        .judge_take  (judge_take),
        .busy        (busy),
        .done        (done),
        .pass        (pass)
    );

    assign rd_req  = busy;
    assign rd_addr = addr_q;

endmodule

// File: rtl/flash_poll_chk.sv
// Protocol checker for the flash completion poller, bound to the top module.
module flash_poll_chk #(
    parameter int ADDR_W    = 24,
    parameter int BUS_BYTES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 rd_req,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic                 done,
    input logic                 pass,
    input logic [BUS_BYTES-1:0] live_q
);
    assert_start_takes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && rd_req));

    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_addr));

    assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    assert_lane_never_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((live_q & ~$past(live_q)) == '0));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !rd_req));

    assert_pass_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass) |-> done);

endmodule

bind flash_poll_top flash_poll_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .done    (done),
    .pass    (pass),
    .live_q  (live_q)
);

// File: tb/flash_poll_top_tb_top.sv
`timescale 1ns/1ps
module flash_poll_top_tb_top;
    localparam int AW = 16;
    localparam int BB = 4;
    localparam int MP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic [31:0] expect_word = '0;
    logic [1:0]  bus_width_sel = '0;
    logic [1:0]  chip_width_sel = '0;
    logic [7:0]  tmo_mask = '0;
    logic        rd_req;
    logic [AW-1:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        busy, done, pass;

    int n_checks = 0;
    int n_errs   = 0;

    always #2.5 clk = ~clk;

    flash_poll_top #(.ADDR_W(AW), .BUS_BYTES(BB), .MAX_POLLS(MP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_addr(poll_addr),
        .expect_word(expect_word), .bus_width_sel(bus_width_sel),
        .chip_width_sel(chip_width_sel), .tmo_mask(tmo_mask),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .pass(pass)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_state = 0;   // 0 idle, 1 first read, 2 judging
    bit          m_done = 0, m_pass = 0;
    logic [AW-1:0] m_addr = '0;
    logic [31:0] m_exp = '0, m_last = '0;
    logic [7:0]  m_tmo = '0;
    bit          m_live[4];
    int          m_bw = 1, m_cw = 1, m_cnt = 0;

    function automatic int width_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 2;
            default: return 4;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_done = 0; m_pass = 0;
        end else begin
            m_done = 0;
            if (m_state == 0) begin
                if (start) begin
                    m_bw = width_of(bus_width_sel);
                    m_cw = width_of(chip_width_sel);
                    if (m_cw > m_bw) m_cw = m_bw;
                    m_exp = expect_word; m_tmo = tmo_mask; m_addr = poll_addr;
                    for (int k = 0; k < 4; k++) m_live[k] = (k < m_bw);
                    m_cnt = 0; m_pass = 0; m_state = 1;
                end
            end else if (m_state == 1) begin
                if (rd_ack) begin m_last = rd_data; m_state = 2; end
            end else if (rd_ack) begin
                logic [31:0] msk;
                bit          fin, ok, tmo_hit;
                msk = '0;
                for (int k = 0; k < 4; k++) if (m_live[k]) msk[8*k +: 8] = 8'hFF;
                fin = 0; ok = 0; tmo_hit = 0;
                if ((rd_data & msk) == (m_exp & msk)) begin fin = 1; ok = 1; end
                else if ((rd_data & msk) == (m_last & msk)) fin = 1;
                else begin
                    for (int l = 0; l < m_bw; l += m_cw) begin
                        bit alive;
                        alive = 0;
                        for (int k = l; k < l + m_cw; k++) alive |= m_live[k];
                        if (alive && ((rd_data[8*l +: 8] & m_tmo) != 0)) tmo_hit = 1;
                    end
                    m_cnt++;
                    if (tmo_hit || m_cnt == MP) fin = 1;
                end
                if (fin) begin
                    m_done = 1; m_pass = ok; m_state = 0;
                end else begin
                    for (int l = 0; l < m_bw; l += m_cw) begin
                        bit same;
                        same = 1;
                        for (int k = l; k < l + m_cw; k++)
                            if (rd_data[8*k +: 8] != m_exp[8*k +: 8]) same = 0;
                        if (same) for (int k = l; k < l + m_cw; k++) m_live[k] = 0;
                    end
                    m_last = rd_data;
                end
            end
        end
    end

    // Compare the design against the model on every cycle, away from the edge.
    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(busy == (m_state != 0), "R1 busy vs model", 32'(busy), 32'(m_state != 0));
            chk(rd_req == (m_state != 0), "R2 rd_req vs model", 32'(rd_req), 32'(m_state != 0));
            if (m_state != 0) chk(rd_addr == m_addr, "R1 rd_addr vs model", 32'(rd_addr), 32'(m_addr));
            chk(done == m_done, "R9 done vs model", 32'(done), 32'(m_done));
            chk(pass == m_pass, "R9 pass vs model", 32'(pass), 32'(m_pass));
        end
    end

    // ---------------- stimulus ----------------
    logic [31:0] vals[$];

    task automatic run(input logic [1:0] bs, input logic [1:0] cs, input logic [7:0] tm,
                       input logic [31:0] ex, input logic [AW-1:0] ad,
                       input bit exp_pass, input string tag, input bit poke_start);
        @(negedge clk);
        bus_width_sel = bs; chip_width_sel = cs; tmo_mask = tm;
        expect_word = ex; poll_addr = ad; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && rd_req, {tag, " run started"}, 32'(busy), 32'd1);
        foreach (vals[i]) begin
            if (i % 2 == 1) begin rd_ack = 1'b0; @(negedge clk); end
            if (poke_start && i == 1) begin start = 1'b1; poll_addr = ~ad; end
            rd_ack = 1'b1; rd_data = vals[i];
            @(negedge clk);
            start = 1'b0;
            if (i < vals.size() - 1)
                chk(busy && !done, {tag, " still running"}, 32'(busy), 32'd1);
        end
        rd_ack = 1'b0;
        chk(done == 1'b1, {tag, " done pulse"}, 32'(done), 32'd1);
        chk(pass == exp_pass, {tag, " result"}, 32'(pass), 32'(exp_pass));
        chk(busy == 1'b0, {tag, " idle after end"}, 32'(busy), 32'd0);
        @(negedge clk);
        chk(done == 1'b0 && pass == exp_pass, {tag, " R9 done drops, pass held"}, 32'(pass), 32'(exp_pass));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy && !rd_req && !done && !pass, "R10 reset outputs low",
            {28'd0, busy, rd_req, done, pass}, 32'd0);
        @(negedge clk); rst_n = 1'b1; cmp_on = 1;

        // R2: acknowledge while idle has no effect
        rd_ack = 1'b1; rd_data = 32'hFFFF_FFFF;
        repeat (3) begin
            @(negedge clk);
            chk(!busy && !done, "R2 idle ack ignored", 32'(busy), 32'd0);
        end
        rd_ack = 1'b0;

        // R4 + R1: pass on 4-byte bus, start pulse during run ignored
        vals = {}; vals.push_back(32'h0); vals.push_back(32'h0000_0040); vals.push_back(32'h1234_5678);
        run(2'd2, 2'd2, 8'h20, 32'h1234_5678, 16'h1A2B, 1'b1, "R4/R1 match", 1'b1);

        // R4: bytes above a 1-byte bus ignored
        vals = {}; vals.push_back(32'h11); vals.push_back(32'hDEAD_00AB);
        run(2'd0, 2'd0, 8'h00, 32'h0000_00AB, 16'h0010, 1'b1, "R4 upper bytes", 1'b0);

        // R3: first read equal to the expected word is not judged
        vals = {}; vals.push_back(32'hAB); vals.push_back(32'h01); vals.push_back(32'hAB);
        run(2'd0, 2'd0, 8'h00, 32'h0000_00AB, 16'h0020, 1'b1, "R3 prime", 1'b0);

        // R5: repeated value fails
        vals = {}; vals.push_back(32'h0011); vals.push_back(32'h0011);
        run(2'd1, 2'd1, 8'h00, 32'h0000_5555, 16'h0030, 1'b0, "R5 stall", 1'b0);

        // R5: stall judged only on masked bytes
        vals = {}; vals.push_back(32'h1100); vals.push_back(32'h2200);
        run(2'd0, 2'd0, 8'h00, 32'h0000_00AB, 16'h0031, 1'b0, "R5 masked stall", 1'b0);

        // R6: timeout bit in lowest byte of a live lane
        vals = {}; vals.push_back(32'h0); vals.push_back(32'h0000_2000);
        run(2'd2, 2'd0, 8'h20, 32'hFFFF_FFFF, 16'h0040, 1'b0, "R6 timeout", 1'b0);

        // R6: zero mask disables timeout; erase wait with all ones
        vals = {}; vals.push_back(32'h0); vals.push_back(32'h0000_2000); vals.push_back(32'hFFFF_FFFF);
        run(2'd2, 2'd0, 8'h00, 32'hFFFF_FFFF, 16'h0041, 1'b1, "R6 no timeout mask", 1'b0);

        // R6: flagged bit in a non-lowest lane byte ignored
        vals = {}; vals.push_back(32'h0); vals.push_back(32'h2000_0000); vals.push_back(32'h5555_1234);
        run(2'd2, 2'd1, 8'h20, 32'h5555_1234, 16'h0042, 1'b1, "R6 upper lane byte", 1'b0);

        // R7: retired lane ignored afterwards
        vals = {}; vals.push_back(32'h0); vals.push_back(32'h00BB_0000); vals.push_back(32'hAAFF_CCDD);
        run(2'd2, 2'd0, 8'h00, 32'hAABB_CCDD, 16'h0050, 1'b1, "R7 retire", 1'b0);

        // R7: change only in a retired lane counts as stall
        vals = {}; vals.push_back(32'h0); vals.push_back(32'h00BB_0000); vals.push_back(32'h0077_0000);
        run(2'd2, 2'd0, 8'h00, 32'hAABB_CCDD, 16'h0051, 1'b0, "R7 retired stall", 1'b0);

        // R7: chip width wider than bus clamped to bus
        vals = {}; vals.push_back(32'h0); vals.push_back(32'h1200); vals.push_back(32'h7700); vals.push_back(32'h1234);
        run(2'd1, 2'd2, 8'h00, 32'h0000_1234, 16'h0052, 1'b1, "R7 clamp", 1'b0);

        // R8: budget runs out
        vals = {}; for (int k = 0; k <= MP; k++) vals.push_back(32'(k));
        run(2'd0, 2'd0, 8'h00, 32'h0000_00AA, 16'h0060, 1'b0, "R8 budget", 1'b0);

        // R8/R9: match on the last allowed read wins
        vals = {}; for (int k = 0; k < MP; k++) vals.push_back(32'(k)); vals.push_back(32'hAA);
        run(2'd0, 2'd0, 8'h00, 32'h0000_00AA, 16'h0061, 1'b1, "R8 last-read match", 1'b0);

        // R9: match takes priority over a timeout bit
        vals = {}; vals.push_back(32'h0); vals.push_back(32'h20);
        run(2'd0, 2'd0, 8'h20, 32'h0000_0020, 16'h0070, 1'b1, "R9 match over timeout", 1'b0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule